// File: doc/BRIEF.md
# PS/2 Host Frame Receiver

This block takes the clock and data lines of an open-drain PS/2 link, seen from the host side, and turns each device-to-host frame into a checked result. Both lines first pass through two-flop synchronizers. All line sampling then happens on a slow sampling tick that is divided down from the system clock. The nominal tick rate is 200 kHz.

A frame has 11 bits: a start bit, eight data bits sent least significant bit first, an odd-parity bit and a stop bit. The receiver takes one bit in each low period of the device clock. It places the bits in the upper 11 positions of a right-shifting 32-bit capture word, then checks the frame as a whole. Each completed frame gives a one-cycle strobe, a data byte and a 2-bit error code. The same result is written into a small receive FIFO. Firmware polls the FIFO's empty flag and pops entries from it. A transmit-pending input holds the receiver in its idle check so that it does not contend with the host's own sends.

The state machine has four states, with these transitions:
- IDLE to WAIT_LOW: on a tick, when the clock line is low and no transmit is pending.
- WAIT_LOW to WAIT_HIGH: on a tick with the clock low. The data bit is captured at this point.
- WAIT_HIGH to WAIT_LOW: on a tick with the clock high, while fewer than 11 bits have been taken.
- WAIT_HIGH to CHECK: on a tick with the clock high, once all 11 bits have been taken.
- WAIT_LOW or WAIT_HIGH to IDLE: when the frame timer expires. This is the abort path.
- CHECK to IDLE: always, after one cycle.

Top module: `ps2_frame_rx`

## Requirements
- R1: A frame starts only on a tick that sees the synchronized clock line low while `tx_busy_i` is low. While the clock is high, or while `tx_busy_i` is high, the block stays idle and clock pulses produce no result.
- R2: Exactly 11 bits are taken per frame, one in each clock-low period. Line bit 0 is the start bit, bits 1 to 8 are data (least significant bit first), bit 9 is parity and bit 10 is stop. In a good frame, `rx_data_o` equals the data bits.
- R3: A start bit of 1 gives error code 1, with `rx_data_o` equal to 0.
- R4: Parity is odd over the data byte plus the parity bit. A mismatch gives error code 2, with data 0.
- R5: A stop bit of 0 gives error code 3, with data 0. When a frame has several faults, the start error outranks the parity error, and the parity error outranks the stop error.
- R6: Each completed frame raises `rx_valid_o` for exactly one cycle. A good frame reports error code 0.
- R7: `rx_err_o` and `rx_data_o` keep their values until the next frame completes.
- R8: Each completed frame is written to the FIFO as the entry {error[9:8], data[7:0]}. `fifo_data_o` shows the oldest entry. `fifo_empty_o` is 1 when the FIFO holds no entries. Asserting `fifo_pop_i` removes the oldest entry.
- R9: A frame that completes while the FIFO is full is dropped from the FIFO. The entries already stored are unchanged, although `rx_valid_o` still strobes for that frame.
- R10: A frame still incomplete `TIMEOUT_TICKS` ticks after it started is aborted. The abort produces no strobe and no FIFO entry, and clears the bit count so that the next frame is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ps2_clk_i | input | 1 | PS/2 clock line as read from the pad |
| ps2_dat_i | input | 1 | PS/2 data line as read from the pad |
| tx_busy_i | input | 1 | Host transmit pending; holds the receiver idle |
| rx_valid_o | output | 1 | One-cycle strobe per completed frame |
| rx_data_o | output | 8 | Received byte, 0 on error |
| rx_err_o | output | 2 | 0 none, 1 start, 2 parity, 3 stop |
| fifo_pop_i | input | 1 | Remove the oldest FIFO entry |
| fifo_empty_o | output | 1 | FIFO holds no entries |
| fifo_data_o | output | 10 | Oldest entry: {error, data} |

## Verification
The hardest situations to reach from the ports are a frame that completes into a full FIFO, and a frame that stalls part-way until the timer aborts it. To reach the first, the bench shrinks the FIFO depth and sends one more frame than the FIFO can hold without popping. It then drains the FIFO and checks that only the earlier bytes come out. To reach the second, it sends four bits and then holds the clock high past the timeout. A complete frame follows, and it decodes correctly only if the bit count was cleared by the abort.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;
    typedef enum logic [1:0] {
        RX_IDLE      = 2'd0,
        RX_WAIT_LOW  = 2'd1,
        RX_WAIT_HIGH = 2'd2,
        RX_CHECK     = 2'd3
    } rx_state_e;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_START  = 2'd1,
        ERR_PARITY = 2'd2,
        ERR_STOP   = 2'd3
    } rx_err_e;

    typedef struct packed {
        rx_err_e    err;
        logic [7:0] data;
    } rx_result_t;
endpackage

// File: rtl/ps2rx_tick.sv
module ps2rx_tick #(
    parameter int DIV = 1250
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    generate
        if (DIV < 2) begin : g_pass
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt_q;
            logic          tick_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q  <= '0;
                    tick_q <= 1'b0;
                end else if (cnt_q == CW'(DIV - 1)) begin
                    cnt_q  <= '0;
                    tick_q <= 1'b1;
                end else begin
                    cnt_q  <= cnt_q + 1'b1;
                    tick_q <= 1'b0;
                end
            end
            assign tick_o = tick_q;
        end
    endgenerate
endmodule

// File: rtl/ps2rx_sync.sv
module ps2rx_sync #(
    parameter int         W       = 2,
    parameter logic       RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic meta_q, stab_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta_q <= RST_VAL;
                    stab_q <= RST_VAL;
                end else begin
                    meta_q <= d_i[i];
                    stab_q <= meta_q;
                end
            end
            assign q_o[i] = stab_q;
        end
    endgenerate
endmodule

// File: rtl/ps2rx_fifo.sv
module ps2rx_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] wdata_i,
    input  logic         pop_i,
    output logic [W-1:0] rdata_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [AW:0]   cnt_q;
    logic          do_push, do_pop;

    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == (AW+1)'(DEPTH));
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign rdata_o = mem[rd_q];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= nxt(wr_q);
            if (do_pop)  rd_q <= nxt(rd_q);
            cnt_q <= cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i && !pop_i) |=> ($stable(cnt_q) && $stable(wr_q))); // R9
    AST_EMPTY_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && pop_i && !push_i) |=> $stable(rd_q)); // R8
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
    import ps2rx_pkg::*;
#(
    parameter int TICK_DIV      = 1250,
    parameter int TIMEOUT_TICKS = 400,
    parameter int FIFO_DEPTH    = 32,
    parameter int WORD_W        = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ps2_clk_i,
    input  logic       ps2_dat_i,
    input  logic       tx_busy_i,
    output logic       rx_valid_o,
    output logic [7:0] rx_data_o,
    output logic [1:0] rx_err_o,
    input  logic       fifo_pop_i,
    output logic       fifo_empty_o,
    output logic [9:0] fifo_data_o
);
    localparam int FRAME_BITS = 11;
    localparam int BASE       = WORD_W - FRAME_BITS;
    localparam int BCW        = $clog2(FRAME_BITS + 1);
    localparam int TW         = $clog2(TIMEOUT_TICKS + 1);
    localparam int POS_START  = BASE;
    localparam int POS_DATA   = BASE + 1;
    localparam int POS_PAR    = BASE + 9;
    localparam int POS_STOP   = BASE + 10;

    logic       tick;
    logic [1:0] lines_s;
    logic       clk_s, dat_s;

    ps2rx_tick #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    ps2rx_sync #(.W(2), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({ps2_clk_i, ps2_dat_i}), .q_o(lines_s)
    );
    assign clk_s = lines_s[1];
    assign dat_s = lines_s[0];

    rx_state_e               state_q, state_d;
    logic [WORD_W-1:BASE]    frame_q;
    logic [BCW-1:0]          bits_q;
    logic [TW-1:0]           age_q;
    logic                    timed_out;
    logic                    valid_q;
    rx_result_t              res_q, chk;
    logic                    fifo_full;

    assign timed_out = (age_q == TW'(TIMEOUT_TICKS));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: begin
                if (tick && !clk_s && !tx_busy_i) state_d = RX_WAIT_LOW;
            end
            RX_WAIT_LOW: begin
                if (tick) begin
                    if (timed_out)   state_d = RX_IDLE;
                    else if (!clk_s) state_d = RX_WAIT_HIGH;
                end
            end
            RX_WAIT_HIGH: begin
                if (tick) begin
                    if (timed_out)  state_d = RX_IDLE;
                    else if (clk_s) state_d = (bits_q == BCW'(FRAME_BITS)) ? RX_CHECK : RX_WAIT_LOW;
                end
            end
            RX_CHECK: state_d = RX_IDLE;
            default:  state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        logic [7:0] d;
        d   = frame_q[POS_DATA+7:POS_DATA];
        chk = '{err: ERR_NONE, data: d};
        if (frame_q[POS_START])             chk = '{err: ERR_START,  data: 8'h00};
        else if (!(^{d, frame_q[POS_PAR]})) chk = '{err: ERR_PARITY, data: 8'h00};
        else if (!frame_q[POS_STOP])        chk = '{err: ERR_STOP,   data: 8'h00};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0;
            bits_q  <= '0;
            age_q   <= '0;
            valid_q <= 1'b0;
            res_q   <= '{err: ERR_NONE, data: 8'h00};
        end else begin
            valid_q <= (state_q == RX_CHECK);
            if (state_q == RX_CHECK) res_q <= chk;
            if (state_q == RX_IDLE) begin
                bits_q <= '0;
                age_q  <= '0;
            end else if (tick && (state_q == RX_WAIT_LOW || state_q == RX_WAIT_HIGH)) begin
                age_q <= age_q + 1'b1;
                if (state_q == RX_WAIT_LOW && !clk_s && !timed_out) begin
                    frame_q <= {dat_s, frame_q[WORD_W-1:BASE+1]};
                    bits_q  <= bits_q + 1'b1;
                end
            end
        end
    end

    assign rx_valid_o = valid_q;
    assign rx_data_o  = res_q.data;
    assign rx_err_o   = res_q.err;

    ps2rx_fifo #(.DEPTH(FIFO_DEPTH), .W(10)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_i(state_q == RX_CHECK), .wdata_i(chk),
        .pop_i(fifo_pop_i), .rdata_o(fifo_data_o),
        .empty_o(fifo_empty_o), .full_o(fifo_full)
    );

    AST_BUSY_KEEPS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_IDLE && tx_busy_i) |=> (state_q == RX_IDLE)); // R1
    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o); // R6
    AST_ERROR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_o && rx_err_o != 2'd0) |-> (rx_data_o == 8'h00)); // R3
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid_o |-> ($stable(rx_err_o) && $stable(rx_data_o))); // R7
    AST_CHECK_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_CHECK) |-> (bits_q == BCW'(FRAME_BITS))); // R2
endmodule

// File: tb/sim_ps2_frame_rx.sv
module sim_ps2_frame_rx;
    localparam int DIV   = 4;
    localparam int TO    = 400;
    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ps2_clk = 1'b1, ps2_dat = 1'b1, tx_busy = 1'b0, fifo_pop = 1'b0;
    logic       rx_valid_o, fifo_empty_o;
    logic [7:0] rx_data_o;
    logic [1:0] rx_err_o;
    logic [9:0] fifo_data_o;

    int n_chk = 0, n_fail = 0, n_valid = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ps2_frame_rx #(.TICK_DIV(DIV), .TIMEOUT_TICKS(TO), .FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .ps2_clk_i(ps2_clk), .ps2_dat_i(ps2_dat),
        .tx_busy_i(tx_busy), .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o),
        .rx_err_o(rx_err_o), .fifo_pop_i(fifo_pop), .fifo_empty_o(fifo_empty_o),
        .fifo_data_o(fifo_data_o)
    );

    always @(negedge clk) if (rst_n && rx_valid_o) n_valid++;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [10:0] raw, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            ps2_dat = raw[i];
            idle(16);
            ps2_clk = 1'b0;
            idle(32);
            ps2_clk = 1'b1;
            idle(16);
        end
        ps2_dat = 1'b1;
    endtask

    function automatic logic [10:0] mk(input logic st, input logic sp, input logic pf, input logic [7:0] d);
        return {sp, (~^d) ^ pf, d, st};
    endfunction

    function automatic logic [9:0] model(input logic [10:0] raw);
        logic [7:0] d;
        d = raw[8:1];
        if (raw[0])           return {2'd1, 8'h00};
        if (!(^{d, raw[9]}))  return {2'd2, 8'h00};
        if (!raw[10])         return {2'd3, 8'h00};
        return {2'd0, d};
    endfunction

    task automatic pop_check(input string req, input int exp);
        check(req, "fifo not empty", int'(fifo_empty_o), 0);
        check(req, "fifo entry", int'(fifo_data_o), exp);
        fifo_pop = 1'b1;
        idle(1);
        fifo_pop = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // {start, stop, parity_flip, data}; last two entries exercise R5 priority
    localparam logic [10:0] TBL [9] = '{
        {1'b0, 1'b1, 1'b0, 8'h1C},
        {1'b0, 1'b1, 1'b0, 8'hF0},
        {1'b0, 1'b1, 1'b0, 8'h00},
        {1'b0, 1'b1, 1'b0, 8'hFF},
        {1'b1, 1'b1, 1'b0, 8'h5A},
        {1'b0, 1'b1, 1'b1, 8'hA5},
        {1'b0, 1'b0, 1'b0, 8'h3C},
        {1'b1, 1'b0, 1'b1, 8'h11},
        {1'b0, 1'b0, 1'b1, 8'h22}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [10:0] raw;
        logic [9:0]  exp;
        int          v0;
        string       req;
        idle(5);
        rst_n = 1'b1;
        idle(5);
        check("R8", "reset empty", int'(fifo_empty_o), 1);
        check("R6", "reset valid", int'(rx_valid_o), 0);
        check("R7", "reset err", int'(rx_err_o), 0);
        check("R7", "reset data", int'(rx_data_o), 0);

        for (int i = 0; i < 9; i++) begin
            raw = mk(TBL[i][10], TBL[i][9], TBL[i][8], TBL[i][7:0]);
            exp = model(raw);
            case (exp[9:8])
                2'd0: req = "R2";
                2'd1: req = "R3";
                2'd2: req = "R4";
                default: req = "R5";
            endcase
            v0 = n_valid;
            send_bits(raw, 11);
            idle(40);
            check("R6", "strobe count", n_valid - v0, 1);
            check(req, "err code", int'(rx_err_o), int'(exp[9:8]));
            check(req, "data", int'(rx_data_o), int'(exp[7:0]));
            pop_check("R8", int'(exp));
            check("R8", "empty after pop", int'(fifo_empty_o), 1);
        end

        // R7: result held long after the last frame
        idle(300);
        check("R7", "err held", int'(rx_err_o), 2);
        check("R7", "data held", int'(rx_data_o), 0);

        // R1: clock pulses ignored while transmit pending
        v0 = n_valid;
        tx_busy = 1'b1;
        send_bits(mk(1'b0, 1'b1, 1'b0, 8'h77), 11);
        idle(40);
        tx_busy = 1'b0;
        idle(20);
        check("R1", "no strobe while busy", n_valid - v0, 0);
        check("R1", "fifo empty while busy", int'(fifo_empty_o), 1);
        send_bits(mk(1'b0, 1'b1, 1'b0, 8'h33), 11);
        idle(40);
        check("R1", "frame after busy", int'(rx_data_o), 8'h33);
        pop_check("R1", 10'h033);

        // R10: stalled frame aborted, next frame clean
        v0 = n_valid;
        send_bits(mk(1'b0, 1'b1, 1'b0, 8'h99), 4);
        idle(TO * DIV + 200);
        check("R10", "no strobe on abort", n_valid - v0, 0);
        check("R10", "no entry on abort", int'(fifo_empty_o), 1);
        send_bits(mk(1'b0, 1'b1, 1'b0, 8'h42), 11);
        idle(40);
        check("R10", "data after abort", int'(rx_data_o), 8'h42);
        check("R10", "err after abort", int'(rx_err_o), 0);
        pop_check("R10", 10'h042);

        // R9: one frame more than the FIFO holds
        v0 = n_valid;
        for (int k = 0; k < DEPTH + 1; k++) begin
            send_bits(mk(1'b0, 1'b1, 1'b0, 8'(8'h10 + k)), 11);
            idle(40);
        end
        check("R9", "strobes incl dropped", n_valid - v0, DEPTH + 1);
        check("R9", "last byte on outputs", int'(rx_data_o), 8'h10 + DEPTH);
        for (int k = 0; k < DEPTH; k++) pop_check("R9", 8'h10 + k);
        check("R9", "dropped frame absent", int'(fifo_empty_o), 1);

        finish_run();
    end
endmodule